// File: doc/BRIEF.md
# Unlock-Gated Protected Page Writer

This block guards an eight-byte protected nonvolatile page behind a serial slave front end. The front end decodes bus traffic into events: start, stop, a write or a read of the unlock register, an address byte, a data byte, and a data read. The block returns one acknowledge decision per byte event, together with read data. The page array is made of flip-flops, and a programmable countdown stands in for the nonvolatile write time.

Writing to the page needs a two-value key. The key must be written to the unlock register as 0x55 and then 0xAA, inside one bus transaction. Data bytes are staged in an eight-entry page buffer whose pointer wraps in its low three bits. A per-byte valid mask records which entries were received. On stop, only the received entries are copied into the array, the key is withdrawn, and `busy` is raised for `WR_CYCLES` clocks. While `busy` is high, protected-array bytes are refused. Reads of the array never need the key.

Events arrive on a valid/ready stream, and responses leave on a valid/ready stream. `ev_ready` is `!rsp_valid || rsp_ready`. An event is taken when `ev_valid && ev_ready`. Each byte event leaves one response in the response register one cycle later. That response is held there until `rsp_ready`. Start and stop produce no response.

Top module: `prot_page_writer`

## Requirements
- R1: An address byte is acknowledged only when its upper five bits are 5'b11110 (0xF0..0xF7) and `busy` is low. After a refused address, the data bytes and reads that follow are refused and nothing is written. A good address in the very next transaction is accepted.
- R2: Data bytes are stored only after two unlock-register writes, 0x55 then 0xAA, each acknowledged. Without the key, a data byte is acknowledged but has no effect on the array.
- R3: A wrong second key value, or a start or stop between the two key writes, leaves the block locked.
- R4: A stop that ends a transaction with an accepted address while unlocked relocks the block. The next write needs a new key.
- R5: A read of the unlock register is acknowledged and returns 0x00.
- R6: Array reads need no key. Each read returns the byte at the pointer, then the pointer's low three bits advance.
- R7: More than eight data bytes in one transaction wrap the pointer and overwrite earlier buffered bytes.
- R8: Buffered bytes reach the array only at stop. Only the entries received since the last accepted address are written, and the other bytes keep their contents.
- R9: A commit holds `busy` high for exactly `WR_CYCLES` clocks. During that time, address, data and array-read bytes are refused, while unlock-register accesses are still acknowledged.
- R10: After a write, the pointer addresses the byte after the last one written, so a following read without an address returns that byte.
- R11: Every byte event yields exactly one response, with `rsp_valid` high from the next cycle. The response holds stable while `rsp_ready` is low, and `ev_ready` is low during that time.
- R12: Event kind codes: 0 start, 1 stop, 2 unlock write, 3 unlock read, 4 address, 5 data, 6 array read. The array resets to all zeros and the pointer to 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_kind | input | 3 | Event kind code (R12) |
| ev_byte | input | 8 | Byte carried by the event |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ack | output | 1 | Acknowledge decision for the byte |
| rsp_data | output | 8 | Read data, zero for non-read events |
| busy | output | 1 | Internal write cycle running |

## Verification
The assertions assume that the front end offers only the kind codes 0 to 6. They also assume that `ev_kind` and `ev_byte` stay steady while an event waits for `ev_ready`. The bench drives every event on the falling edge and keeps it for exactly one accepted cycle. It holds `rsp_ready` high except in the back-pressure scenario, where it keeps the event inputs constant until the event is taken. Key sequences are always framed by start and stop, just as the front end would frame them.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_STOP   = 3'd1,
    EV_KEY_WR = 3'd2,
    EV_KEY_RD = 3'd3,
    EV_ADDR   = 3'd4,
    EV_DATA   = 3'd5,
    EV_READ   = 3'd6
  } ev_kind_t;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/ppw_unlock.sv
module ppw_unlock
  import ppw_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       frame_evt,
  input  logic       relock,
  output logic       key_open
);
  key_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_LOCKED;
    end else if (relock) begin
      state_q <= KS_LOCKED;
    end else if (key_wr) begin
      case (state_q)
        KS_HALF: state_q <= (key_byte == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
        default: state_q <= (key_byte == KEY_FIRST) ? KS_HALF : KS_LOCKED;
      endcase
    end else if (frame_evt && state_q == KS_HALF) begin
      state_q <= KS_LOCKED;
    end
  end

  assign key_open = (state_q == KS_OPEN);
endmodule

// File: rtl/ppw_wr_timer.sv
module ppw_wr_timer #(
  parameter int WR_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ppw_page_store.sv
module ppw_page_store #(
  parameter int PAGE_BYTES = 8,
  localparam int PTR_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_mask,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             any_valid
);
  logic [7:0]            stage_q [PAGE_BYTES];
  logic [7:0]            cell_q  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        cell_q[i]  <= '0;
        mask_q[i]  <= 1'b0;
      end else begin
        if (hit) stage_q[i] <= wr_byte;
        if (clr_mask)  mask_q[i] <= 1'b0;
        else if (hit)  mask_q[i] <= 1'b1;
        if (commit && mask_q[i]) cell_q[i] <= stage_q[i];
      end
    end
  end

  assign rd_byte   = cell_q[rd_idx];
  assign any_valid = |mask_q;
endmodule

// File: rtl/prot_page_writer.sv
module prot_page_writer
  import ppw_pkg::*;
#(
  parameter int         PAGE_BYTES = 8,
  parameter logic [7:0] BASE_ADDR  = 8'hF0,
  parameter int         WR_CYCLES  = 40,
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       rsp_ack,
  output logic [7:0] rsp_data,
  output logic       busy
);
  localparam int PTR_W = $clog2(PAGE_BYTES);

  ev_kind_t         kind;
  logic             acc, in_win, key_open, any_valid;
  logic             addr_ack, data_ack, read_ack;
  logic             is_byte_evt, do_stop, commit, relock, wr_en, clr_mask;
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_ok_q, sess_addr_q, wr_seen_q;
  logic [7:0]       cell_byte;
  logic             ack_d;
  logic [7:0]       data_d;

  assign kind     = ev_kind_t'(ev_kind);
  assign ev_ready = !rsp_valid || rsp_ready;
  assign acc      = ev_valid && ev_ready;
  assign in_win   = (ev_byte[7:PTR_W] == BASE_ADDR[7:PTR_W]);

  assign addr_ack = !busy && in_win;
  assign data_ack = !busy && sess_addr_q;
  assign read_ack = !busy && ptr_ok_q;

  assign is_byte_evt = (kind == EV_KEY_WR) || (kind == EV_KEY_RD) || (kind == EV_ADDR)
                    || (kind == EV_DATA)   || (kind == EV_READ);
  assign do_stop  = acc && (kind == EV_STOP);
  assign relock   = do_stop && wr_seen_q;
  assign commit   = relock && any_valid;
  assign wr_en    = acc && (kind == EV_DATA) && data_ack && key_open;
  assign clr_mask = acc && (kind == EV_ADDR) && addr_ack;

  ppw_unlock #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (acc && (kind == EV_KEY_WR)),
    .key_byte  (ev_byte),
    .frame_evt (acc && ((kind == EV_START) || (kind == EV_STOP))),
    .relock    (relock),
    .key_open  (key_open)
  );

  ppw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit),
    .busy  (busy)
  );

  ppw_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_mask  (clr_mask),
    .wr_en     (wr_en),
    .wr_idx    (ptr_q),
    .wr_byte   (ev_byte),
    .commit    (commit),
    .rd_idx    (ptr_q),
    .rd_byte   (cell_byte),
    .any_valid (any_valid)
  );

  always_comb begin
    ack_d  = 1'b0;
    data_d = 8'h00;
    case (kind)
      EV_KEY_WR, EV_KEY_RD: ack_d = 1'b1;
      EV_ADDR:              ack_d = addr_ack;
      EV_DATA:              ack_d = data_ack;
      EV_READ: begin
        ack_d  = read_ack;
        data_d = read_ack ? cell_byte : 8'h00;
      end
      default: ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      ptr_ok_q    <= 1'b1;
      sess_addr_q <= 1'b0;
      wr_seen_q   <= 1'b0;
    end else if (acc) begin
      case (kind)
        EV_START: sess_addr_q <= 1'b0;
        EV_STOP: begin
          sess_addr_q <= 1'b0;
          wr_seen_q   <= 1'b0;
        end
        EV_ADDR: begin
          ptr_ok_q    <= addr_ack;
          sess_addr_q <= addr_ack;
          if (addr_ack) ptr_q <= ev_byte[PTR_W-1:0];
          if (addr_ack && key_open) wr_seen_q <= 1'b1;
        end
        EV_DATA: if (data_ack) ptr_q <= ptr_q + 1'b1;
        EV_READ: if (read_ack) ptr_q <= ptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (acc && is_byte_evt) begin
      rsp_valid <= 1'b1;
      rsp_ack   <= ack_d;
      rsp_data  <= data_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [2:0] ev_kind,
  input logic [7:0] ev_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_ack,
  input logic [7:0] rsp_data,
  input logic       busy,
  input logic       key_open
);
  logic acc;
  assign acc = ev_valid && ev_ready;

  assert_window_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == 3'd4 && ev_byte[7:3] != 5'b11110 |=> rsp_valid && !rsp_ack);

  assert_key_opens_on_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_open) |-> $past(acc && ev_kind == 3'd2 && ev_byte == KEY_SECOND));

  assert_key_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == 3'd3 |=> rsp_valid && rsp_ack && rsp_data == 8'h00);

  assert_busy_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc && ev_kind == 3'd1));

  assert_busy_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && busy && (ev_kind == 3'd4 || ev_kind == 3'd5 || ev_kind == 3'd6)
    |=> rsp_valid && !rsp_ack);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack) && $stable(rsp_data));

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !ev_ready);
endmodule

bind prot_page_writer ppw_checker #(.KEY_SECOND(KEY_SECOND)) u_ppw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_kind   (ev_kind),
  .ev_byte   (ev_byte),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ack   (rsp_ack),
  .rsp_data  (rsp_data),
  .busy      (busy),
  .key_open  (key_open)
);

// File: tb/tb_prot_page_writer.sv
module tb_prot_page_writer;
  localparam int WRC = 40;
  localparam logic [2:0] K_START = 3'd0, K_STOP = 3'd1, K_KWR = 3'd2, K_KRD = 3'd3,
                         K_ADDR = 3'd4, K_DATA = 3'd5, K_READ = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, rsp_ready = 1'b1;
  logic ev_ready, rsp_valid, rsp_ack, busy;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00, rsp_data;

  int n_checks = 0, n_fail = 0;
  logic [7:0] model [8];
  logic       ack;
  logic [7:0] dat;

  always #10 clk = ~clk;

  prot_page_writer #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_data(rsp_data), .busy(busy)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] b,
                      output logic a, output logic [7:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
    a = rsp_ack; d = rsp_data;
  endtask

  task automatic unlock();
    send(K_START, 8'h00, ack, dat);
    send(K_KWR, 8'h55, ack, dat);
    send(K_KWR, 8'hAA, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    logic k;
    send(K_START, 8'h00, k, d);
    send(K_ADDR, a, k, d);
    send(K_START, 8'h00, k, d);
    send(K_READ, 8'h00, k, d);
    send(K_STOP, 8'h00, k, dat);
  endtask

  task automatic t_reset();
    check(!busy && !rsp_valid && ev_ready, "R12 reset outputs", {busy, rsp_valid, ev_ready}, 3'b001);
    send(K_READ, 8'h00, ack, dat);
    check(ack && dat == 8'h00, "R12 reset read at F0", {ack, dat}, 9'h100);
  endtask

  task automatic t_key_read();
    send(K_KRD, 8'h00, ack, dat);
    check(rsp_valid && ack && dat == 8'h00, "R5 unlock register read", {rsp_valid, ack, dat}, 10'h300);
  endtask

  task automatic t_locked_write();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF1, ack, dat);
    send(K_DATA, 8'h77, ack, dat);
    check(ack, "R2 locked data acked", ack, 1);
    send(K_STOP, 8'h00, ack, dat);
    check(!busy, "R2 no commit when locked", busy, 0);
    read_at(8'hF1, dat);
    check(dat == model[1], "R2 locked write ignored", dat, model[1]);
  endtask

  task automatic t_bad_keys();
    send(K_START, 8'h00, ack, dat);
    send(K_KWR, 8'h55, ack, dat);
    send(K_KWR, 8'h33, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF0, ack, dat);
    send(K_DATA, 8'h12, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    check(!busy, "R3 wrong second key", busy, 0);
    send(K_START, 8'h00, ack, dat);
    send(K_KWR, 8'h55, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    send(K_START, 8'h00, ack, dat);
    send(K_KWR, 8'hAA, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF0, ack, dat);
    send(K_DATA, 8'h12, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    check(!busy, "R3 stop between keys", busy, 0);
    read_at(8'hF0, dat);
    check(dat == model[0], "R3 array untouched", dat, model[0]);
  endtask

  task automatic t_partial_write();
    unlock();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF2, ack, dat);
    check(ack, "R1 F2 address acked", ack, 1);
    for (int i = 0; i < 3; i++) begin
      send(K_DATA, 8'h20 + 8'(i), ack, dat);
      model[2 + i] = 8'h20 + 8'(i);
    end
    check(!busy, "R8 nothing before stop", busy, 0);
    send(K_STOP, 8'h00, ack, dat);
    begin
      int cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
      check(cnt == WRC, "R9 busy length", cnt, WRC);
    end
    send(K_START, 8'h00, ack, dat);
    send(K_READ, 8'h00, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    check(dat == model[5], "R10 pointer after write", dat, model[5]);
    for (int i = 0; i < 8; i++) begin
      read_at(8'hF0 + 8'(i), dat);
      check(dat == model[i], "R8 array contents", dat, model[i]);
    end
  endtask

  task automatic t_relock();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF3, ack, dat);
    send(K_DATA, 8'hEE, ack, dat);
    send(K_STOP, 8'h00, ack, dat);
    check(!busy, "R4 relocked after write", busy, 0);
    read_at(8'hF3, dat);
    check(dat == model[3], "R4 second write ignored", dat, model[3]);
  endtask

  task automatic t_wrap();
    unlock();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF6, ack, dat);
    for (int k = 0; k < 10; k++) begin
      send(K_DATA, 8'hD0 + 8'(k), ack, dat);
      model[(6 + k) % 8] = 8'hD0 + 8'(k);
    end
    send(K_STOP, 8'h00, ack, dat);
    wait_idle();
    send(K_START, 8'h00, ack, dat);
    for (int i = 0; i < 8; i++) begin
      send(K_READ, 8'h00, ack, dat);
      check(ack && dat == model[i], "R7 R6 wrapped page read", dat, model[i]);
    end
    send(K_STOP, 8'h00, ack, dat);
  endtask

  task automatic t_window();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF8, ack, dat);
    check(!ack, "R1 F8 refused", ack, 0);
    send(K_DATA, 8'h99, ack, dat);
    check(!ack, "R1 data after bad address", ack, 0);
    send(K_READ, 8'h00, ack, dat);
    check(!ack, "R1 read after bad address", ack, 0);
    send(K_STOP, 8'h00, ack, dat);
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hE7, ack, dat);
    check(!ack, "R1 E7 refused", ack, 0);
    send(K_ADDR, 8'hF7, ack, dat);
    check(ack, "R1 F7 accepted at once", ack, 1);
    send(K_STOP, 8'h00, ack, dat);
  endtask

  task automatic t_busy_refuse();
    unlock();
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF0, ack, dat);
    send(K_DATA, 8'h5A, ack, dat);
    model[0] = 8'h5A;
    send(K_STOP, 8'h00, ack, dat);
    check(busy, "R9 busy after commit", busy, 1);
    send(K_START, 8'h00, ack, dat);
    send(K_ADDR, 8'hF0, ack, dat);
    check(!ack, "R9 address refused while busy", ack, 0);
    send(K_READ, 8'h00, ack, dat);
    check(!ack, "R9 read refused while busy", ack, 0);
    send(K_KRD, 8'h00, ack, dat);
    check(ack, "R9 unlock access while busy", ack, 1);
    send(K_STOP, 8'h00, ack, dat);
    wait_idle();
    read_at(8'hF0, dat);
    check(dat == 8'h5A, "R8 byte write committed", dat, 8'h5A);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = K_KRD; ev_byte = 8'h00;
    @(negedge clk);
    ev_kind = K_KWR;
    check(rsp_valid && !ev_ready, "R11 response pending stalls", {rsp_valid, ev_ready}, 2'b10);
    @(negedge clk);
    check(rsp_valid && !ev_ready && rsp_ack && rsp_data == 8'h00, "R11 response held",
          {rsp_valid, ev_ready}, 2'b10);
    rsp_ready = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    check(rsp_valid && rsp_ack, "R11 queued event answered", {rsp_valid, rsp_ack}, 2'b11);
    @(negedge clk);
    check(!rsp_valid, "R11 response drained", rsp_valid, 0);
    send(K_STOP, 8'h00, ack, dat);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key_read();
    t_locked_write();
    t_bad_keys();
    t_partial_write();
    t_relock();
    t_wrap();
    t_window();
    t_busy_refuse();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule